// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block sits between one package pin and the core logic. A static configuration picks one of five operating modes: plain combinational input, input captured by a flip-flop on the I/O clock, input held by a level-sensitive latch, always-driven output, or bidirectional pin whose driver is gated by a core output enable. A second, per-cell configuration bit chooses how the driver behaves. Push-pull drive forces both levels. Open-drain drive only ever pulls the pin low and lets an external pull-up supply the high level.

The core side offers a data bit to drive, an output enable and a returned input bit. The pin side is a single bidirectional wire. It comes with a drive-enable flag that shows when the cell is actively driving. Every cell carries its own configuration, so many cells placed side by side can mix drive types freely. The all-zero configuration gives a safe, non-driving combinational input with push-pull drive selected.

Internally a drive-action decoder names what the driver does in each situation: OFF, PUSH_HI, PUSH_LO, SINK_LO and RELEASE. A capture stage selects the returned input from the live pin, the flip-flop or the latch.

Top module: `pad_cell_top`

## Requirements
- R1: Mode code 0 (combinational input), together with drive-type bit 0 (push-pull), is the all-zero configuration. In it the driver is off and `core_din` follows the pin with no clock involved.
- R2: In mode code 1 (registered input), `core_din` takes the pin value sampled at a rising edge of `clk` and holds it until the next rising edge.
- R3: In mode code 2 (latched input), `core_din` follows the pin while `lat_en` is 1. It keeps the last followed value while `lat_en` is 0.
- R4: In modes 0, 1 and 2, and in the unused codes 5 to 7 (which behave as combinational input), `pad_oe` is 0 and the cell never drives the pin, whatever `core_dout` and `core_oe` are.
- R5: In mode code 3 (output), the driver is enabled regardless of `core_oe`, subject to R8.
- R6: In mode code 4 (bidirectional), the driver is enabled only while `core_oe` is 1, subject to R8.
- R7: With drive-type bit 0 (push-pull), an enabled driver puts `core_dout` on the pin for both levels.
- R8: With drive-type bit 1 (open-drain), an enabled driver pulls the pin to 0 when `core_dout` is 0. When `core_dout` is 1 it releases the pin: `pad_oe` is 0 and the pin reads the pulled-up 1.
- R9: In modes 3 and 4, `core_din` returns the live pin value combinationally.
- R10: While `rst_n` is 0, the registered and latched capture paths hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O capture clock |
| rst_n | input | 1 | Asynchronous active-low reset of the capture paths |
| cfg_mode | input | 3 | Operating mode code (0 comb in, 1 registered in, 2 latched in, 3 output, 4 bidirectional) |
| cfg_odrain | input | 1 | Drive type: 0 push-pull, 1 open-drain |
| core_dout | input | 1 | Data from the core to drive onto the pin |
| core_oe | input | 1 | Core output enable, used in bidirectional mode |
| lat_en | input | 1 | Latch transparency enable for latched-input mode |
| core_din | output | 1 | Pin value returned to the core |
| pad_oe | output | 1 | High while the cell actively drives the pin |
| pad_io | inout | 1 | Package pin |

## Verification
The bench sweeps every mode code against both drive types, both data levels and both enable levels. It checks `pad_oe` and the resolved pin value on a wire with a pull-up. A cell that drove a high in open-drain mode, or that ignored `core_oe` in bidirectional mode, shows up as a wrong pin level or a wrong enable flag. The registered path is checked just after a clock edge and again after the pin moves before the next edge, which catches a capture that is transparent or a cycle late. The latch is checked both open and closed, which catches a latch that never closes. Reset checks and checks on the unused codes catch capture paths that come out of reset non-zero and spurious drive on the reserved codes.

// File: rtl/pad_cell_pkg.sv
package pad_cell_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_IN_COMB  = 3'd0,
        MODE_IN_REG   = 3'd1,
        MODE_IN_LATCH = 3'd2,
        MODE_OUT      = 3'd3,
        MODE_BIDIR    = 3'd4
    } pad_mode_e;

    typedef enum logic [2:0] {
        ACT_OFF,
        ACT_PUSH_HI,
        ACT_PUSH_LO,
        ACT_SINK_LO,
        ACT_RELEASE
    } drive_act_e;

    function automatic pad_mode_e decode_mode(input logic [MODE_W-1:0] code);
        pad_mode_e m;
        unique case (code)
            3'd1:    m = MODE_IN_REG;
            3'd2:    m = MODE_IN_LATCH;
            3'd3:    m = MODE_OUT;
            3'd4:    m = MODE_BIDIR;
            default: m = MODE_IN_COMB;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pad_drive_ctl.sv
module pad_drive_ctl
    import pad_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pad_mode_e mode,
    input  logic      odrain,
    input  logic      dout,
    input  logic      oe,
    output logic      drv_en,
    output logic      drv_val
);

    logic       want_drive;
    drive_act_e act;

    always_comb begin
        unique case (mode)
            MODE_OUT:   want_drive = 1'b1;
            MODE_BIDIR: want_drive = oe;
            default:    want_drive = 1'b0;
        endcase
    end

    always_comb begin
        if (!want_drive)
            act = ACT_OFF;
        else if (odrain)
            act = dout ? ACT_RELEASE : ACT_SINK_LO;
        else
            act = dout ? ACT_PUSH_HI : ACT_PUSH_LO;
    end

    always_comb begin
        drv_en  = 1'b0;
        drv_val = 1'b0;
        unique case (act)
            ACT_PUSH_HI: begin drv_en = 1'b1; drv_val = 1'b1; end
            ACT_PUSH_LO: begin drv_en = 1'b1; drv_val = 1'b0; end
            ACT_SINK_LO: begin drv_en = 1'b1; drv_val = 1'b0; end
            ACT_RELEASE: begin drv_en = 1'b0; drv_val = 1'b0; end
            default:     begin drv_en = 1'b0; drv_val = 1'b0; end
        endcase
    end

    assert_input_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_OUT && mode != MODE_BIDIR) |-> !drv_en);

    assert_output_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OUT && !odrain) |-> drv_en);

    assert_bidir_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BIDIR && !oe) |-> !drv_en);

    assert_odrain_low_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (odrain && drv_en) |-> (drv_val == 1'b0));

    assert_totem_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!odrain && drv_en) |-> (drv_val == dout));

endmodule

// File: rtl/pad_capture.sv
module pad_capture
    import pad_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pad_mode_e mode,
    input  logic      pin_in,
    input  logic      lat_en,
    output logic      din
);

    logic reg_q;
    logic lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_q <= 1'b0;
        else
            reg_q <= pin_in;
    end

    always_latch begin
        if (!rst_n)
            lat_q = 1'b0;
        else if (lat_en)
            lat_q = pin_in;
    end

    always_comb begin
        unique case (mode)
            MODE_IN_REG:   din = reg_q;
            MODE_IN_LATCH: din = lat_q;
            default:       din = pin_in;
        endcase
    end

    assert_reg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (reg_q == $past(pin_in)));

    assert_latch_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lat_en |-> (lat_q == pin_in));

    always_comb begin
        if (!rst_n && (mode == MODE_IN_REG || mode == MODE_IN_LATCH))
            assert_reset_clear_R10: assert (din == 1'b0);
    end

endmodule

// File: rtl/pad_cell_top.sv
module pad_cell_top
    import pad_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_odrain,
    input  logic       core_dout,
    input  logic       core_oe,
    input  logic       lat_en,
    output logic       core_din,
    output logic       pad_oe,
    inout  wire        pad_io
);

    pad_mode_e mode;
    logic      drv_en;
    logic      drv_val;
    logic      pin_in;

    assign mode = decode_mode(cfg_mode);

    pad_drive_ctl u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .odrain  (cfg_odrain),
        .dout    (core_dout),
        .oe      (core_oe),
        .drv_en  (drv_en),
        .drv_val (drv_val)
    );

    assign pad_io = drv_en ? drv_val : 1'bz;
    assign pin_in = pad_io;
    assign pad_oe = drv_en;

    pad_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .pin_in (pin_in),
        .lat_en (lat_en),
        .din    (core_din)
    );

    assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OUT || mode == MODE_BIDIR) |-> (core_din == pad_io));

endmodule

// File: tb/pad_cell_top_tb_top.sv
module pad_cell_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_odrain = 1'b0;
    logic       core_dout = 1'b0;
    logic       core_oe = 1'b0;
    logic       lat_en = 1'b0;
    logic       ext_en = 1'b0;
    logic       ext_val = 1'b0;
    logic       core_din;
    logic       pad_oe;
    tri1        pad_w;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign pad_w = ext_en ? ext_val : 1'bz;

    pad_cell_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_odrain (cfg_odrain),
        .core_dout  (core_dout),
        .core_oe    (core_oe),
        .lat_en     (lat_en),
        .core_din   (core_din),
        .pad_oe     (pad_oe),
        .pad_io     (pad_w)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0; ext_en = 1'b1; ext_val = 1'b1; lat_en = 1'b1;
        cfg_mode = 3'd1; #1;
        chk("R10", "reg path in reset", core_din, 1'b0);
        cfg_mode = 3'd2; #1;
        chk("R10", "latch path in reset", core_din, 1'b0);
        cfg_mode = 3'd0; lat_en = 1'b0; #1;
        chk("R1", "erased cfg no drive", pad_oe, 1'b0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_comb_input;
        cfg_mode = 3'd0; cfg_odrain = 1'b0; ext_en = 1'b1;
        ext_val = 1'b0; #1;
        chk("R1", "comb follows 0", core_din, 1'b0);
        ext_val = 1'b1; #1;
        chk("R1", "comb follows 1", core_din, 1'b1);
        ext_en = 1'b0; #1;
        chk("R1", "comb reads pull-up", core_din, 1'b1);
    endtask

    task automatic t_reg_input;
        cfg_mode = 3'd1; ext_en = 1'b1;
        @(negedge clk); ext_val = 1'b0;
        @(posedge clk); #1;
        chk("R2", "captured 0", core_din, 1'b0);
        ext_val = 1'b1; #2;
        chk("R2", "holds before edge", core_din, 1'b0);
        @(posedge clk); #1;
        chk("R2", "captured 1", core_din, 1'b1);
        ext_val = 1'b0; #2;
        chk("R2", "holds 1 before edge", core_din, 1'b1);
    endtask

    task automatic t_latch_input;
        cfg_mode = 3'd2; ext_en = 1'b1; lat_en = 1'b1;
        ext_val = 1'b1; #1;
        chk("R3", "open follows 1", core_din, 1'b1);
        ext_val = 1'b0; #1;
        chk("R3", "open follows 0", core_din, 1'b0);
        lat_en = 1'b0; #1;
        ext_val = 1'b1; #1;
        chk("R3", "closed holds 0", core_din, 1'b0);
        @(posedge clk); #1;
        chk("R3", "closed holds across clock", core_din, 1'b0);
        lat_en = 1'b1; #1;
        chk("R3", "reopen follows 1", core_din, 1'b1);
        lat_en = 1'b0;
    endtask

    task automatic t_drive_matrix;
        ext_en = 1'b0;
        for (int m = 0; m < 8; m++) begin
            for (int v = 0; v < 8; v++) begin
                logic exp_oe;
                logic exp_pin;
                logic want;
                cfg_mode   = 3'(m);
                cfg_odrain = v[2];
                core_dout  = v[1];
                core_oe    = v[0];
                @(negedge clk);
                want    = (m == 3) || (m == 4 && v[0]);
                exp_oe  = want && (!v[2] || !v[1]);
                exp_pin = exp_oe ? v[1] : 1'b1;
                if (m == 3)
                    chk("R5", "output mode oe", pad_oe, exp_oe);
                else if (m == 4)
                    chk("R6", "bidir oe", pad_oe, exp_oe);
                else
                    chk("R4", "input mode oe", pad_oe, 1'b0);
                if (v[2])
                    chk("R8", "open-drain pin", pad_w, exp_pin);
                else
                    chk("R7", "push-pull pin", pad_w, exp_pin);
                if (m == 3 || m == 4)
                    chk("R9", "readback", core_din, exp_pin);
            end
        end
    endtask

    task automatic t_bidir_receive;
        cfg_mode = 3'd4; cfg_odrain = 1'b0; core_oe = 1'b0; core_dout = 1'b1;
        ext_en = 1'b1; ext_val = 1'b0; #1;
        chk("R9", "bidir receives 0", core_din, 1'b0);
        chk("R6", "bidir released", pad_oe, 1'b0);
        cfg_mode = 3'd6; core_oe = 1'b1; ext_val = 1'b1; #1;
        chk("R4", "reserved code acts as comb input", core_din, 1'b1);
        ext_en = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_comb_input();
        t_reg_input();
        t_latch_input();
        t_drive_matrix();
        t_bidir_receive();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule